// File: doc/BRIEF.md
# Host Command Mailbox Decoder

This block is a single-word mailbox through which a processor hands commands to a host environment. The surrounding address decoder raises a write or read request only when the mailbox address is hit. A store of 1 to 8 bytes is zero-extended to a 64-bit command word and stored. In the same cycle the word is split into an 8-bit device selector, an 8-bit command code and a 48-bit payload, and it is acted upon.

Two paths are decoded. The exit path is device 0. It sets a sticky completion flag and records an exit status. The terminal path is device 1. It sends one output character per write. Other encodings produce a one-cycle diagnostic pulse and change nothing. A periodic platform tick clears the stored word to zero, and the processor can poll this as an acknowledgement. An 8-byte load returns the stored word. A load of any other width faults.

The write side has no back-pressure: every request is taken in the cycle it is presented. The terminal character comes out as a one-cycle strobe with its data. The consumer must take it in that cycle, because it cannot stall the block. All other pins are plain control and status levels.

Top module: `mbx_host_mailbox`

## Requirements
- R1: After reset the stored word, the completion flag and the exit status are all zero. An 8-byte load then returns 0.
- R2: A write with a byte count of 1 to 8 stores the low count×8 bits of the write data, with zeros above them. The stored word can be read from the next cycle.
- R3: A write with a byte count of 0 or 9 to 15 raises `wr_err` in the same cycle. The stored word does not change, and nothing is decoded.
- R4: A load with count 8 returns the stored word with `rd_err` low. A load with any other count returns 0 and raises `rd_err`.
- R5: `tick` clears the stored word in the next cycle. If an accepted write comes in the same cycle, the write wins.
- R6: The device selector is bits 63:56, the command code is bits 55:48 and the payload is bits 47:0. For device 0 with payload bit 0 set, the completion flag is 1 and the exit status is the payload shifted right by one, zero-extended. Both take effect from the next cycle.
- R7: For device 0 with payload bit 0 clear, the flag and the exit status keep their values, and no diagnostic pulse is raised.
- R8: Device 1 with command 1 pulses `term_valid` in the write cycle, with `term_char` equal to payload bits 7:0.
- R9: Device 1 with command 0 is accepted with no output, no diagnostic pulse and no change of state.
- R10: Any device above 1, and device 1 with a command above 1, pulses `bad_cmd` in the write cycle and changes no flag or status.
- R11: Once set, the completion flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Platform tick; clears the stored word |
| wr_en | input | 1 | Write request (address hit) |
| wr_bytes | input | 4 | Write byte count |
| wr_data | input | 64 | Write data, right-aligned |
| wr_err | output | 1 | Write rejected for its byte count |
| rd_en | input | 1 | Read request (address hit) |
| rd_bytes | input | 4 | Read byte count |
| rd_data | output | 64 | Read data |
| rd_err | output | 1 | Load access fault |
| term_valid | output | 1 | One-cycle terminal character strobe |
| term_char | output | 8 | Terminal character |
| bad_cmd | output | 1 | One-cycle unknown command or device pulse |
| done | output | 1 | Sticky completion flag |
| exit_code | output | 64 | Recorded exit status |

## Verification
The hardest cases to reach are those where earlier commands would hide the effect. Writes narrower than 8 bytes are zero-extended, so each one decodes as device 0. The size sweep therefore uses data with payload bit 0 clear, which keeps the completion flag low. Only then does the bench issue an exit command. After that it sends a second device-0 write with bit 0 clear, to show that the status holds and the flag stays set. The race between a tick and a write is created by presenting both in one cycle and then reading the word back.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  localparam int WORD_W = 64;
  localparam int DEV_W  = 8;
  localparam int CMD_W  = 8;
  localparam int PAY_W  = WORD_W - DEV_W - CMD_W;

  typedef struct packed {
    logic [DEV_W-1:0] dev;
    logic [CMD_W-1:0] cmd;
    logic [PAY_W-1:0] pay;
  } cmd_word_t;

  typedef enum logic [1:0] {
    ACT_NONE = 2'd0,
    ACT_EXIT = 2'd1,
    ACT_TERM = 2'd2,
    ACT_BAD  = 2'd3
  } act_e;

  localparam logic [DEV_W-1:0] DEV_SYS  = 8'd0;
  localparam logic [DEV_W-1:0] DEV_TERM = 8'd1;
  localparam logic [CMD_W-1:0] TCMD_IN  = 8'd0;
  localparam logic [CMD_W-1:0] TCMD_OUT = 8'd1;
endpackage

// File: rtl/mbx_store_fmt.sv
module mbx_store_fmt #(
  parameter int BYTES  = 8,
  parameter int SIZE_W = 4
) (
  input  logic [SIZE_W-1:0]  size,
  input  logic [BYTES*8-1:0] data,
  output logic               ok,
  output logic [BYTES*8-1:0] word
);
  assign ok = (size != '0) && (size <= SIZE_W'(BYTES));

  for (genvar b = 0; b < BYTES; b++) begin : g_lane
    assign word[b*8 +: 8] = (SIZE_W'(b) < size) ? data[b*8 +: 8] : 8'h00;
  end
endmodule

// File: rtl/mbx_cmd_decode.sv
module mbx_cmd_decode
  import mbx_pkg::*;
(
  input  logic              valid,
  input  cmd_word_t         word,
  output act_e              act,
  output logic [7:0]        ch,
  output logic [WORD_W-1:0] exit_val
);
  always_comb begin
    act = ACT_NONE;
    if (valid) begin
      if (word.dev == DEV_SYS) begin
        if (word.pay[0]) act = ACT_EXIT;
      end else if (word.dev == DEV_TERM) begin
        if (word.cmd == TCMD_OUT)     act = ACT_TERM;
        else if (word.cmd != TCMD_IN) act = ACT_BAD;
      end else begin
        act = ACT_BAD;
      end
    end
  end

  assign ch       = word.pay[7:0];
  assign exit_val = {{(WORD_W-PAY_W+1){1'b0}}, word.pay[PAY_W-1:1]};
endmodule

// File: rtl/mbx_readback.sv
module mbx_readback #(
  parameter int BYTES  = 8,
  parameter int SIZE_W = 4
) (
  input  logic               rd_en,
  input  logic [SIZE_W-1:0]  rd_bytes,
  input  logic [BYTES*8-1:0] stored,
  output logic [BYTES*8-1:0] rd_data,
  output logic               rd_err
);
  logic full;
  assign full    = (rd_bytes == SIZE_W'(BYTES));
  assign rd_data = (rd_en && full) ? stored : '0;
  assign rd_err  = rd_en && !full;
endmodule

// File: rtl/mbx_host_mailbox.sv
module mbx_host_mailbox
  import mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              wr_en,
  input  logic [3:0]        wr_bytes,
  input  logic [WORD_W-1:0] wr_data,
  output logic              wr_err,
  input  logic              rd_en,
  input  logic [3:0]        rd_bytes,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_err,
  output logic              term_valid,
  output logic [7:0]        term_char,
  output logic              bad_cmd,
  output logic              done,
  output logic [WORD_W-1:0] exit_code
);
  localparam int BYTES  = WORD_W / 8;
  localparam int SIZE_W = 4;

  logic              size_ok;
  logic              wr_acc;
  logic [WORD_W-1:0] ext_word;
  logic [WORD_W-1:0] stored_q;
  act_e              act;
  logic [WORD_W-1:0] exit_nxt;

  mbx_store_fmt #(.BYTES(BYTES), .SIZE_W(SIZE_W)) u_fmt (
    .size (wr_bytes),
    .data (wr_data),
    .ok   (size_ok),
    .word (ext_word)
  );

  assign wr_acc = wr_en && size_ok;
  assign wr_err = wr_en && !size_ok;

  mbx_cmd_decode u_dec (
    .valid    (wr_acc),
    .word     (cmd_word_t'(ext_word)),
    .act      (act),
    .ch       (term_char),
    .exit_val (exit_nxt)
  );

  assign term_valid = (act == ACT_TERM);
  assign bad_cmd    = (act == ACT_BAD);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stored_q  <= '0;
      done      <= 1'b0;
      exit_code <= '0;
    end else begin
      if (wr_acc)    stored_q <= ext_word;
      else if (tick) stored_q <= '0;
      if (act == ACT_EXIT) begin
        done      <= 1'b1;
        exit_code <= exit_nxt;
      end
    end
  end

  mbx_readback #(.BYTES(BYTES), .SIZE_W(SIZE_W)) u_rb (
    .rd_en    (rd_en),
    .rd_bytes (rd_bytes),
    .stored   (stored_q),
    .rd_data  (rd_data),
    .rd_err   (rd_err)
  );
endmodule

// File: rtl/mbx_host_mailbox_chk.sv
module mbx_host_mailbox_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        wr_en,
  input logic        wr_err,
  input logic        rd_en,
  input logic [3:0]  rd_bytes,
  input logic        rd_err,
  input logic        term_valid,
  input logic        bad_cmd,
  input logic        done,
  input logic [63:0] exit_code,
  input logic [63:0] stored_q
);
  AST_TICK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && !(wr_en && !wr_err)) |=> (stored_q == 64'd0)); // R5
  AST_RD_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && rd_bytes != 4'd8) |-> rd_err); // R4
  AST_TERM_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    term_valid |-> (wr_en && !wr_err)); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({term_valid, bad_cmd, wr_err})); // R10
  AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done); // R11
  AST_BAD_NO_STATE: assert property (@(posedge clk) disable iff (!rst_n)
    bad_cmd |=> ($stable(done) && $stable(exit_code))); // R10
  AST_REJECT_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_err && !tick) |=> $stable(stored_q)); // R3
endmodule

bind mbx_host_mailbox mbx_host_mailbox_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .tick       (tick),
  .wr_en      (wr_en),
  .wr_err     (wr_err),
  .rd_en      (rd_en),
  .rd_bytes   (rd_bytes),
  .rd_err     (rd_err),
  .term_valid (term_valid),
  .bad_cmd    (bad_cmd),
  .done       (done),
  .exit_code  (exit_code),
  .stored_q   (stored_q)
);

// File: tb/test_mbx_host_mailbox.sv
module test_mbx_host_mailbox;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_bytes = 4'd0;
  logic [63:0] wr_data = 64'd0;
  logic        wr_err;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_bytes = 4'd0;
  logic [63:0] rd_data;
  logic        rd_err;
  logic        term_valid;
  logic [7:0]  term_char;
  logic        bad_cmd;
  logic        done;
  logic [63:0] exit_code;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbx_host_mailbox i_mbx_host_mailbox (
    .clk(clk), .rst_n(rst_n), .tick(tick),
    .wr_en(wr_en), .wr_bytes(wr_bytes), .wr_data(wr_data), .wr_err(wr_err),
    .rd_en(rd_en), .rd_bytes(rd_bytes), .rd_data(rd_data), .rd_err(rd_err),
    .term_valid(term_valid), .term_char(term_char), .bad_cmd(bad_cmd),
    .done(done), .exit_code(exit_code)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] zext(input int n, input logic [63:0] d);
    if (n >= 8) return d;
    return d & ((64'd1 << (n*8)) - 64'd1);
  endfunction

  // 8-byte load of the stored word, sampled mid-cycle (inputs driven at negedge)
  task automatic read_word(output logic [63:0] v);
    rd_en = 1'b1; rd_bytes = 4'd8;
    #(CLK_PERIOD/4);
    v = rd_data;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  // one write cycle; samples same-cycle strobes before the edge
  task automatic do_write(input int n, input logic [63:0] d, input bit with_tick,
                          output logic err, output logic tv, output logic [7:0] tc,
                          output logic bad);
    wr_en = 1'b1; wr_bytes = 4'(n); wr_data = d; tick = with_tick;
    #(CLK_PERIOD/4);
    err = wr_err; tv = term_valid; tc = term_char; bad = bad_cmd;
    @(negedge clk);
    wr_en = 1'b0; tick = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin : main
    logic [63:0] v;
    logic e, tv, bad;
    logic [7:0] tc;
    logic [63:0] pat;
    logic [63:0] held;

    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    chk("R1 done", {63'd0, done}, 64'd0);
    chk("R1 exit", exit_code, 64'd0);
    read_word(v);
    chk("R1 word", v, 64'd0);

    // R2/R3 size sweep; payload bit0 clear so device-0 decode never exits
    pat = 64'hA5C3_7E19_2B4D_6F80;
    held = 64'd0;
    for (int n = 0; n < 16; n++) begin
      do_write(n, pat, 1'b0, e, tv, tc, bad);
      if (n >= 1 && n <= 8) begin
        chk("R2 no err", {63'd0, e}, 64'd0);
        held = zext(n, pat);
      end else begin
        chk("R3 err", {63'd0, e}, 64'd1);
        chk("R3 no decode", {62'd0, tv, bad}, 64'd0);
      end
      read_word(v);
      chk(n >= 1 && n <= 8 ? "R2 zero-extend" : "R3 word kept", v, held);
    end
    chk("R7 done untouched", {63'd0, done}, 64'd0);

    // R4 load width sweep
    for (int n = 0; n < 16; n++) begin
      rd_en = 1'b1; rd_bytes = 4'(n);
      #(CLK_PERIOD/4);
      chk("R4 rd_err", {63'd0, rd_err}, (n == 8) ? 64'd0 : 64'd1);
      chk("R4 rd_data", rd_data, (n == 8) ? held : 64'd0);
      @(negedge clk);
      rd_en = 1'b0;
    end

    // R7-R10 decode sweep over devices 0..3, commands 0..3
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 4; c++) begin
        pat = {8'(d), 8'(c), 48'h0000_1234_5642};
        do_write(8, pat, 1'b0, e, tv, tc, bad);
        chk("R8 term strobe", {63'd0, tv}, (d == 1 && c == 1) ? 64'd1 : 64'd0);
        if (d == 1 && c == 1) chk("R8 term char", {56'd0, tc}, 64'h42);
        chk((d == 1 && c == 0) ? "R9 silent" : "R10 bad pulse", {63'd0, bad},
            (d >= 2 || (d == 1 && c >= 2)) ? 64'd1 : 64'd0);
        chk("R7/R10 done kept", {63'd0, done}, 64'd0);
        chk("R7/R10 exit kept", exit_code, 64'd0);
      end
    end

    // R8 character sweep
    for (int k = 0; k < 256; k += 37) begin
      do_write(8, {8'd1, 8'd1, 40'hFF_FFFF_FF00, 8'(k)}, 1'b0, e, tv, tc, bad);
      chk("R8 strobe", {63'd0, tv}, 64'd1);
      chk("R8 char", {56'd0, tc}, 64'(k));
    end

    // R6 exit path
    do_write(8, {8'd0, 8'h77, 48'h8000_0000_1235}, 1'b0, e, tv, tc, bad);
    chk("R6 done", {63'd0, done}, 64'd1);
    chk("R6 exit", exit_code, 64'h0000_4000_0000_091A);
    // R11/R7: device 0 with bit0 clear keeps flag and status
    do_write(8, {8'd0, 8'd0, 48'h0000_0000_0FF0}, 1'b0, e, tv, tc, bad);
    chk("R11 done sticky", {63'd0, done}, 64'd1);
    chk("R7 exit kept", exit_code, 64'h0000_4000_0000_091A);
    // narrow write exits too (zero-extended device 0)
    do_write(1, 64'hFFFF_FFFF_FFFF_FF07, 1'b0, e, tv, tc, bad);
    chk("R6 narrow exit", exit_code, 64'd3);

    // R5 tick acknowledgement
    do_write(8, 64'h0200_0000_0000_0000, 1'b0, e, tv, tc, bad);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    read_word(v);
    chk("R5 tick clears", v, 64'd0);
    do_write(4, 64'h1111_2222_3333_4444, 1'b1, e, tv, tc, bad);
    read_word(v);
    chk("R5 write beats tick", v, 64'h0000_0000_3333_4444);

    // R1 reset again clears everything
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    chk("R1 done after reset", {63'd0, done}, 64'd0);
    chk("R1 exit after reset", exit_code, 64'd0);
    read_word(v);
    chk("R1 word after reset", v, 64'd0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule